// File: doc/BRIEF.md
# Interrupt Vector Cache with Generation-Checked Update

This block keeps a small direct-mapped cache of per-source interrupt state in front of a 64-entry vector table. Each source's state is a pending flag and a two-bit generation count. When an interrupt arrives for a source whose pending flag is clear, the flag is set and a one-cycle delivery pulse carries the source number out. While the flag stays set, further arrivals for that source are absorbed. If the source is not cached, its state is first loaded from the table. Any valid entry that occupies the same slot is written back to the table before the load.

Software closes an interrupt in two steps. First it writes the table byte with the pending flag clear and the generation advanced. Then it issues an update command that asks for the flag to be cleared only if the cached generation still equals the old value. Suppose the cache slot was evicted and refilled by a new arrival between those two steps. The refilled entry then already holds the advanced generation, so the stale command is refused and the fresh pending flag is kept. An update for a source that is not cached is applied to the table entry under the same rule.

Table writes, update commands and arrivals may all be presented in the same cycle. They take effect in that order: the table write first, then the update, then the arrival. Each step sees the result of the step before it.

Top module: `ivc_top`

## Requirements
- R1: After reset every cache slot is invalid and every table entry holds generation 0 with the pending flag clear, and `deliver_o` is low.
- R2: An arrival that finds the source's pending flag clear sets the flag. In the next cycle `deliver_o` is high for exactly one cycle with `deliver_src_o` equal to the arriving source.
- R3: An arrival that finds the pending flag already set raises no delivery.
- R4: The update command word is laid out as: [5:0] source, [6] clear-pending enable, [7] generation-load enable, [8] conditional enable, [10:9] match generation, [12:11] new generation. When bit 8 is 0, the enabled actions always happen: bit 6 clears the flag and bit 7 loads the new generation.
- R5: When bit 8 is 1 and the stored generation equals the match field, the enabled actions happen. This includes the wrap of the generation from 3 to 0.
- R6: When bit 8 is 1 and the stored generation differs from the match field, the stored state is left unchanged.
- R7: After a miss refill that loaded an advanced generation and set the flag, a conditional update that still carries the old generation leaves the flag set.
- R8: The cache is direct-mapped on source bits [2:0]. A miss on a valid slot writes the old entry's flag and generation back to the table, and a later refill returns them intact.
- R9: An update whose source is not cached is applied to the table entry with the same conditional rule.
- R10: In a cycle that carries both an update and an arrival, the update is applied first. A table write in the same cycle is applied before both.
- R11: The table write port stores byte bit 0 as the flag and bits [2:1] as the generation, and ignores bits [7:3]. It does not change a cached copy of that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_valid_i | input | 1 | Interrupt arrival strobe |
| irq_src_i | input | 6 | Arriving source number |
| upd_valid_i | input | 1 | Update command strobe |
| upd_cmd_i | input | 13 | Update command word (layout in R4) |
| tbl_we_i | input | 1 | Table byte write strobe |
| tbl_addr_i | input | 6 | Table entry written |
| tbl_wdata_i | input | 8 | Table byte (layout in R11) |
| deliver_o | output | 1 | One-cycle delivery pulse |
| deliver_src_o | output | 6 | Source number of the delivery |

## Verification
The update path and the arrival path can act on the same source in one cycle. A hit there means the cleared flag is set again at once. A miss there means the table word just written by the update must be forwarded into the refill. The bench drives an unconditional clear together with an arrival for a cached source and expects a delivery, then a second arrival that must not deliver. It also drives a table write, a conditional update and a missing arrival for one uncached source in a single cycle. A follow-up update that matches only the doubly advanced generation shows that each stage saw the one before it.

// File: rtl/ivc_pkg.sv
`timescale 1ns/1ps
package ivc_pkg;
  localparam int unsigned GEN_W = 2;

  typedef struct packed {
    logic [GEN_W-1:0] gen;
    logic             p;
  } ivc_state_t;

  localparam int unsigned ST_W = $bits(ivc_state_t);
endpackage

// File: rtl/ivc_upd_rule.sv
`timescale 1ns/1ps
module ivc_upd_rule
  import ivc_pkg::*;
(
  input  ivc_state_t       cur_i,
  input  logic             en_p_i,
  input  logic             en_gen_i,
  input  logic             en_cond_i,
  input  logic [GEN_W-1:0] match_i,
  input  logic [GEN_W-1:0] new_gen_i,
  output ivc_state_t       nxt_o
);
  logic allow;

  assign allow = !en_cond_i || (cur_i.gen == match_i);

  always_comb begin
    nxt_o = cur_i;
    if (allow) begin
      if (en_p_i)   nxt_o.p   = 1'b0;
      if (en_gen_i) nxt_o.gen = new_gen_i;
    end
  end
endmodule

// File: rtl/ivc_table.sv
`timescale 1ns/1ps
module ivc_table
  import ivc_pkg::*;
#(
  parameter int unsigned SRC_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_W-1:0] rd0_addr_i,
  output ivc_state_t       rd0_o,
  input  logic [SRC_W-1:0] rd1_addr_i,
  output ivc_state_t       rd1_o,
  // write ports in rising priority: software, update miss, eviction
  input  logic             sw_we_i,
  input  logic [SRC_W-1:0] sw_addr_i,
  input  ivc_state_t       sw_data_i,
  input  logic             up_we_i,
  input  logic [SRC_W-1:0] up_addr_i,
  input  ivc_state_t       up_data_i,
  input  logic             ev_we_i,
  input  logic [SRC_W-1:0] ev_addr_i,
  input  ivc_state_t       ev_data_i
);
  localparam int unsigned DEPTH = 1 << SRC_W;

  ivc_state_t mem_q [DEPTH];

  assign rd0_o = mem_q[rd0_addr_i];
  assign rd1_o = mem_q[rd1_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (sw_we_i) mem_q[sw_addr_i] <= sw_data_i;
      if (up_we_i) mem_q[up_addr_i] <= up_data_i;
      if (ev_we_i) mem_q[ev_addr_i] <= ev_data_i;
    end
  end
endmodule

// File: rtl/ivc_cache.sv
`timescale 1ns/1ps
module ivc_cache
  import ivc_pkg::*;
#(
  parameter int unsigned SRC_W = 6,
  parameter int unsigned IDX_W = 3,
  localparam int unsigned TAG_W = SRC_W - IDX_W,
  localparam int unsigned NENT  = 1 << IDX_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [IDX_W-1:0]     ra_idx_i,
  output logic                 ra_valid_o,
  output logic [TAG_W-1:0]     ra_tag_o,
  output ivc_state_t           ra_state_o,
  input  logic [IDX_W-1:0]     rb_idx_i,
  output logic                 rb_valid_o,
  output logic [TAG_W-1:0]     rb_tag_o,
  output ivc_state_t           rb_state_o,
  // state-only write from an update hit
  input  logic                 wu_en_i,
  input  logic [IDX_W-1:0]     wu_idx_i,
  input  ivc_state_t           wu_state_i,
  // full write from an arrival; overrides wu on the same slot
  input  logic                 wi_en_i,
  input  logic [IDX_W-1:0]     wi_idx_i,
  input  logic [TAG_W-1:0]     wi_tag_i,
  input  ivc_state_t           wi_state_i,
  output logic [NENT*ST_W-1:0] state_all_o
);
  logic       vld_q [NENT];
  logic [TAG_W-1:0] tag_q [NENT];
  ivc_state_t st_q  [NENT];

  assign ra_valid_o = vld_q[ra_idx_i];
  assign ra_tag_o   = tag_q[ra_idx_i];
  assign ra_state_o = st_q[ra_idx_i];
  assign rb_valid_o = vld_q[rb_idx_i];
  assign rb_tag_o   = tag_q[rb_idx_i];
  assign rb_state_o = st_q[rb_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < NENT; e++) begin
        vld_q[e] <= 1'b0;
        tag_q[e] <= '0;
        st_q[e]  <= '0;
      end
    end else begin
      if (wu_en_i) st_q[wu_idx_i] <= wu_state_i;
      if (wi_en_i) begin
        vld_q[wi_idx_i] <= 1'b1;
        tag_q[wi_idx_i] <= wi_tag_i;
        st_q[wi_idx_i]  <= wi_state_i;
      end
    end
  end

  for (genvar g = 0; g < NENT; g++) begin : g_flat
    assign state_all_o[g*ST_W +: ST_W] = st_q[g];
  end
endmodule

// File: rtl/ivc_top.sv
`timescale 1ns/1ps
module ivc_top
  import ivc_pkg::*;
#(
  parameter int unsigned SRC_W = 6,
  parameter int unsigned IDX_W = 3,
  localparam int unsigned CMD_W = SRC_W + 3 + 2*GEN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             irq_valid_i,
  input  logic [SRC_W-1:0] irq_src_i,
  input  logic             upd_valid_i,
  input  logic [CMD_W-1:0] upd_cmd_i,
  input  logic             tbl_we_i,
  input  logic [SRC_W-1:0] tbl_addr_i,
  input  logic [7:0]       tbl_wdata_i,
  output logic             deliver_o,
  output logic [SRC_W-1:0] deliver_src_o
);
  localparam int unsigned TAG_W   = SRC_W - IDX_W;
  localparam int unsigned NENT    = 1 << IDX_W;
  localparam int unsigned OFF_ENP = SRC_W;
  localparam int unsigned OFF_ENG = SRC_W + 1;
  localparam int unsigned OFF_CND = SRC_W + 2;
  localparam int unsigned OFF_MT  = SRC_W + 3;
  localparam int unsigned OFF_NG  = SRC_W + 3 + GEN_W;

  // command decode
  logic [SRC_W-1:0] u_src;
  logic             u_en_p, u_en_gen, u_en_cond;
  logic [GEN_W-1:0] u_match, u_ng;
  logic [IDX_W-1:0] u_idx;
  logic [TAG_W-1:0] u_tag;

  assign u_src     = upd_cmd_i[SRC_W-1:0];
  assign u_en_p    = upd_cmd_i[OFF_ENP];
  assign u_en_gen  = upd_cmd_i[OFF_ENG];
  assign u_en_cond = upd_cmd_i[OFF_CND];
  assign u_match   = upd_cmd_i[OFF_MT +: GEN_W];
  assign u_ng      = upd_cmd_i[OFF_NG +: GEN_W];
  assign u_idx     = u_src[IDX_W-1:0];
  assign u_tag     = u_src[SRC_W-1:IDX_W];

  ivc_state_t sw_state;
  logic [7-ST_W:0] unused_wdata_hi;
  assign sw_state        = ivc_state_t'(tbl_wdata_i[ST_W-1:0]);
  assign unused_wdata_hi = tbl_wdata_i[7:ST_W];

  // storage
  logic             ca_valid, cb_valid;
  logic [TAG_W-1:0] ca_tag, cb_tag;
  ivc_state_t       ca_state, cb_state;
  ivc_state_t       tb_rd0, tb_rd1;
  logic [NENT*ST_W-1:0] c_state_all;

  // stage 1: update
  logic       u_hit, u_tbl_we;
  ivc_state_t u_tbl_state, u_cur, u_new;

  // stage 2: arrival
  logic [IDX_W-1:0] i_idx;
  logic [TAG_W-1:0] i_tag;
  logic             i_hit, ev_we;
  ivc_state_t       i_slot_state, i_tbl_state, i_prev, i_new;
  logic [SRC_W-1:0] ev_addr;

  assign u_hit       = upd_valid_i && ca_valid && (ca_tag == u_tag);
  assign u_tbl_state = (tbl_we_i && tbl_addr_i == u_src) ? sw_state : tb_rd0;
  assign u_cur       = u_hit ? ca_state : u_tbl_state;
  assign u_tbl_we    = upd_valid_i && !u_hit;

  ivc_upd_rule u_rule (
    .cur_i     (u_cur),
    .en_p_i    (u_en_p),
    .en_gen_i  (u_en_gen),
    .en_cond_i (u_en_cond),
    .match_i   (u_match),
    .new_gen_i (u_ng),
    .nxt_o     (u_new)
  );

  assign i_idx = irq_src_i[IDX_W-1:0];
  assign i_tag = irq_src_i[SRC_W-1:IDX_W];

  // arrival sees the slot and the table as left by the update
  assign i_slot_state = (u_hit && u_idx == i_idx) ? u_new : cb_state;
  assign i_hit        = irq_valid_i && cb_valid && (cb_tag == i_tag);

  always_comb begin
    if (u_tbl_we && u_src == irq_src_i)            i_tbl_state = u_new;
    else if (tbl_we_i && tbl_addr_i == irq_src_i)  i_tbl_state = sw_state;
    else                                           i_tbl_state = tb_rd1;
  end

  assign i_prev  = i_hit ? i_slot_state : i_tbl_state;
  assign i_new   = '{gen: i_prev.gen, p: 1'b1};
  assign ev_we   = irq_valid_i && !i_hit && cb_valid;
  assign ev_addr = {cb_tag, i_idx};

  ivc_table #(.SRC_W(SRC_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd0_addr_i (u_src),
    .rd0_o      (tb_rd0),
    .rd1_addr_i (irq_src_i),
    .rd1_o      (tb_rd1),
    .sw_we_i    (tbl_we_i),
    .sw_addr_i  (tbl_addr_i),
    .sw_data_i  (sw_state),
    .up_we_i    (u_tbl_we),
    .up_addr_i  (u_src),
    .up_data_i  (u_new),
    .ev_we_i    (ev_we),
    .ev_addr_i  (ev_addr),
    .ev_data_i  (i_slot_state)
  );

  ivc_cache #(.SRC_W(SRC_W), .IDX_W(IDX_W)) u_cache (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ra_idx_i    (u_idx),
    .ra_valid_o  (ca_valid),
    .ra_tag_o    (ca_tag),
    .ra_state_o  (ca_state),
    .rb_idx_i    (i_idx),
    .rb_valid_o  (cb_valid),
    .rb_tag_o    (cb_tag),
    .rb_state_o  (cb_state),
    .wu_en_i     (u_hit),
    .wu_idx_i    (u_idx),
    .wu_state_i  (u_new),
    .wi_en_i     (irq_valid_i),
    .wi_idx_i    (i_idx),
    .wi_tag_i    (i_tag),
    .wi_state_i  (i_new),
    .state_all_o (c_state_all)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      deliver_o     <= 1'b0;
      deliver_src_o <= '0;
    end else begin
      deliver_o <= irq_valid_i && !i_prev.p;
      if (irq_valid_i && !i_prev.p) deliver_src_o <= irq_src_i;
    end
  end
endmodule

// File: rtl/ivc_chk.sv
`timescale 1ns/1ps
module ivc_chk
  import ivc_pkg::*;
#(
  parameter int unsigned SRC_W = 6,
  parameter int unsigned IDX_W = 3,
  localparam int unsigned NENT = 1 << IDX_W
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 irq_valid_i,
  input logic [SRC_W-1:0]     irq_src_i,
  input logic                 upd_valid_i,
  input logic                 deliver_o,
  input logic [SRC_W-1:0]     deliver_src_o,
  input logic                 u_hit_i,
  input logic                 u_en_p_i,
  input logic                 u_en_cond_i,
  input logic [GEN_W-1:0]     u_match_i,
  input logic [IDX_W-1:0]     u_idx_i,
  input ivc_state_t           u_cur_i,
  input logic [NENT*ST_W-1:0] c_state_all_i
);
  logic [IDX_W-1:0] idx_q;
  ivc_state_t       exp_q;
  logic [ST_W-1:0]  slot_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      exp_q <= '0;
    end else begin
      idx_q <= u_idx_i;
      exp_q <= u_cur_i;
    end
  end

  assign slot_now = c_state_all_i[idx_q*ST_W +: ST_W];

  a_r2_deliver_follows_arrival: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deliver_o |-> ($past(irq_valid_i) && deliver_src_o == $past(irq_src_i)));

  a_r2_single_cycle_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deliver_o && !irq_valid_i) |=> !deliver_o);

  a_r3_no_repeat_delivery: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_valid_i && !upd_valid_i && $past(irq_valid_i) && $past(irq_src_i) == irq_src_i)
      |=> !deliver_o);

  a_r4_uncond_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && u_hit_i && !u_en_cond_i && u_en_p_i && !irq_valid_i)
      |=> (slot_now[0] == 1'b0));

  a_r6_mismatch_keeps_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && u_hit_i && u_en_cond_i && (u_match_i != u_cur_i.gen) && !irq_valid_i)
      |=> (slot_now == exp_q));
endmodule

bind ivc_top ivc_chk #(.SRC_W(SRC_W), .IDX_W(IDX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .irq_valid_i   (irq_valid_i),
  .irq_src_i     (irq_src_i),
  .upd_valid_i   (upd_valid_i),
  .deliver_o     (deliver_o),
  .deliver_src_o (deliver_src_o),
  .u_hit_i       (u_hit),
  .u_en_p_i      (u_en_p),
  .u_en_cond_i   (u_en_cond),
  .u_match_i     (u_match),
  .u_idx_i       (u_idx),
  .u_cur_i       (ca_state),
  .c_state_all_i (c_state_all)
);

// File: tb/ivc_top_tb.sv
`timescale 1ns/1ps
module ivc_top_tb;
  localparam int SW = 6;
  localparam int CW = 13;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          irq_valid = 1'b0;
  logic [SW-1:0] irq_src = '0;
  logic          upd_valid = 1'b0;
  logic [CW-1:0] upd_cmd = '0;
  logic          tbl_we = 1'b0;
  logic [SW-1:0] tbl_addr = '0;
  logic [7:0]    tbl_wdata = '0;
  logic          deliver;
  logic [SW-1:0] deliver_src;

  int n_chk  = 0;
  int n_fail = 0;
  logic          got_d;
  logic [SW-1:0] got_s;

  always #2.5 clk = ~clk;

  ivc_top u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .irq_valid_i   (irq_valid),
    .irq_src_i     (irq_src),
    .upd_valid_i   (upd_valid),
    .upd_cmd_i     (upd_cmd),
    .tbl_we_i      (tbl_we),
    .tbl_addr_i    (tbl_addr),
    .tbl_wdata_i   (tbl_wdata),
    .deliver_o     (deliver),
    .deliver_src_o (deliver_src)
  );

  function automatic logic [CW-1:0] mk(input logic [SW-1:0] s, input logic ep, input logic eg,
                                       input logic ec, input logic [1:0] m, input logic [1:0] ng);
    return {ng, m, ec, eg, ep, s};
  endfunction

  // one cycle of stimulus; result sampled at the following negedge
  task automatic cyc(input logic iv, input logic [SW-1:0] is, input logic uv, input logic [CW-1:0] uc,
                     input logic tw, input logic [SW-1:0] ta, input logic [7:0] td);
    irq_valid = iv; irq_src = is; upd_valid = uv; upd_cmd = uc;
    tbl_we = tw; tbl_addr = ta; tbl_wdata = td;
    @(posedge clk);
    @(negedge clk);
    got_d = deliver; got_s = deliver_src;
    irq_valid = 1'b0; upd_valid = 1'b0; tbl_we = 1'b0;
  endtask

  task automatic chk(input string req, input logic exp_d, input logic [SW-1:0] exp_s);
    n_chk++;
    if (got_d !== exp_d || (exp_d && got_s !== exp_s)) begin
      n_fail++;
      $display("FAIL %s: deliver=%0b src=%0d, expected deliver=%0b src=%0d",
               req, got_d, got_s, exp_d, exp_s);
    end
  endtask

  task automatic irq(input logic [SW-1:0] s); cyc(1'b1, s, 1'b0, '0, 1'b0, '0, '0); endtask
  task automatic upd(input logic [CW-1:0] c); cyc(1'b0, '0, 1'b1, c, 1'b0, '0, '0); endtask
  task automatic twr(input logic [SW-1:0] a, input logic [7:0] d); cyc(1'b0, '0, 1'b0, '0, 1'b1, a, d); endtask

  task automatic t_reset;
    cyc(1'b0, '0, 1'b0, '0, 1'b0, '0, '0);
    chk("R1 idle after reset", 1'b0, '0);
    irq(6'd5); chk("R1 R2 first arrival from zeroed table", 1'b1, 6'd5);
  endtask

  task automatic t_repeat;
    irq(6'd5); chk("R3 repeat arrival", 1'b0, '0);
    irq(6'd5); chk("R3 third arrival", 1'b0, '0);
  endtask

  task automatic t_uncond;
    upd(mk(6'd5, 1, 1, 0, 2'd3, 2'd2)); chk("R4 update cycle quiet", 1'b0, '0);
    irq(6'd5); chk("R4 unconditional clear", 1'b1, 6'd5);
    upd(mk(6'd5, 0, 1, 0, 2'd0, 2'd1));
    irq(6'd5); chk("R4 gen-only load keeps flag", 1'b0, '0);
    upd(mk(6'd5, 1, 1, 1, 2'd1, 2'd3));
    irq(6'd5); chk("R5 match on loaded gen", 1'b1, 6'd5);
  endtask

  task automatic t_cond;
    upd(mk(6'd5, 1, 1, 1, 2'd0, 2'd1));
    irq(6'd5); chk("R6 mismatch keeps flag", 1'b0, '0);
    upd(mk(6'd5, 1, 1, 1, 2'd3, 2'd0));
    irq(6'd5); chk("R5 wrap 3 to 0", 1'b1, 6'd5);
    upd(mk(6'd5, 1, 0, 1, 2'd0, 2'd3));
    irq(6'd5); chk("R5 gen is 0 after wrap", 1'b1, 6'd5);
  endtask

  task automatic t_race;
    irq(6'd9);  chk("R2 source 9", 1'b1, 6'd9);
    irq(6'd17); chk("R8 conflicting source 17", 1'b1, 6'd17);
    twr(6'd9, 8'h02);
    irq(6'd9);  chk("R7 refill with advanced gen delivers", 1'b1, 6'd9);
    upd(mk(6'd9, 1, 1, 1, 2'd0, 2'd1));
    irq(6'd9);  chk("R7 stale update keeps flag", 1'b0, '0);
    upd(mk(6'd9, 1, 1, 1, 2'd1, 2'd2));
    irq(6'd9);  chk("R7 current update clears", 1'b1, 6'd9);
  endtask

  task automatic t_evict;
    irq(6'd17); chk("R8 written-back flag of 17", 1'b0, '0);
    irq(6'd9);  chk("R8 written-back flag of 9", 1'b0, '0);
    upd(mk(6'd9, 1, 1, 1, 2'd2, 2'd0));
    irq(6'd9);  chk("R8 written-back gen of 9", 1'b1, 6'd9);
  endtask

  task automatic t_miss_upd;
    twr(6'd33, 8'h03);
    upd(mk(6'd33, 1, 1, 1, 2'd0, 2'd2));
    irq(6'd33); chk("R9 table mismatch unchanged", 1'b0, '0);
    irq(6'd41); chk("R9 evicting 33", 1'b1, 6'd41);
    upd(mk(6'd33, 1, 1, 1, 2'd1, 2'd3));
    irq(6'd33); chk("R9 table match cleared", 1'b1, 6'd33);
    upd(mk(6'd33, 1, 0, 1, 2'd3, 2'd0));
    irq(6'd33); chk("R9 table took new gen", 1'b1, 6'd33);
  endtask

  task automatic t_same_cycle;
    irq(6'd2); chk("R2 source 2", 1'b1, 6'd2);
    cyc(1'b1, 6'd2, 1'b1, mk(6'd2, 1, 0, 0, 2'd0, 2'd0), 1'b0, '0, '0);
    chk("R10 hit: update before arrival", 1'b1, 6'd2);
    irq(6'd2); chk("R10 flag set after joint cycle", 1'b0, '0);
    cyc(1'b1, 6'd10, 1'b1, mk(6'd10, 1, 1, 0, 2'd0, 2'd1), 1'b0, '0, '0);
    chk("R10 miss: refill sees update", 1'b1, 6'd10);
    upd(mk(6'd10, 1, 0, 1, 2'd1, 2'd0));
    irq(6'd10); chk("R10 forwarded gen", 1'b1, 6'd10);
    cyc(1'b1, 6'd18, 1'b1, mk(6'd18, 0, 1, 1, 2'd2, 2'd3), 1'b1, 6'd18, 8'h04);
    chk("R10 table write, update, arrival in one cycle", 1'b1, 6'd18);
    upd(mk(6'd18, 1, 0, 1, 2'd3, 2'd0));
    irq(6'd18); chk("R10 three-stage gen", 1'b1, 6'd18);
  endtask

  task automatic t_table_port;
    twr(6'd18, 8'h00);
    irq(6'd18); chk("R11 table write leaves cached copy", 1'b0, '0);
    twr(6'd50, 8'hF9);
    irq(6'd50); chk("R11 upper byte bits ignored, flag set", 1'b0, '0);
    upd(mk(6'd50, 1, 0, 1, 2'd0, 2'd0));
    irq(6'd50); chk("R11 gen 0 from byte", 1'b1, 6'd50);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_repeat();
    t_uncond();
    t_cond();
    t_race();
    t_evict();
    t_miss_upd();
    t_same_cycle();
    t_table_port();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule